// File: doc/BRIEF.md
# Reset Sequencer with Source Flags

This block turns three reset sources into two system reset outputs. The sources are a digital supply-good indication from a voltage comparator, an external active-low reset pin and a watchdog request. One output is the general system reset. The other covers the watchdog domain as well. When the supply is low, both outputs assert at once, without waiting for a clock edge. Once every source has gone quiet, a counter holds reset for a fixed number of clock cycles and then both outputs are released together on a clock edge.

A three-bit flag register records which source caused the last reset, and software reads it through a simple register port. A supply drop rewrites the register to hold only the power-on flag. Software clears individual flags by writing ones to their bit positions.

The controller has three named states:
- `ST_STRETCH`: both outputs asserted; this is also the state the block enters while the supply is low.
- `ST_WDT`: only the watchdog-domain output asserted.
- `ST_RUN`: both outputs released.

The transitions are:
- `hold`: `ST_STRETCH` stays in `ST_STRETCH` while any source is active or the counter is non-zero.
- `release`: `ST_STRETCH` or `ST_WDT` moves to `ST_RUN` when no source is active and the counter reads zero.
- `escalate`: `ST_RUN` or `ST_WDT` moves to `ST_STRETCH` when the external pin is active.
- `wdog_trip`: `ST_RUN` moves to `ST_WDT` on a watchdog request.
- `wdog_hold`: `ST_WDT` stays in `ST_WDT` while the request stays high or the counter is non-zero.

Top module: `rsq_reset_seq`

## Requirements
- R1: While `supply_ok` is low, `sys_rst` and `wdt_sys_rst` are both 1 and `flag_rdata` reads 0x01. This takes effect immediately, with no clock edge needed.
- R2: After `supply_ok` rises, both outputs stay 1 through the first DELAY_CYC-1 rising clock edges and drop to 0 after the DELAY_CYC-th edge.
- R3: A supply drop during the stretch period or during normal operation restarts the full period of R2 from the moment the supply rises again.
- R4: `ext_rst_n` low passes through a two-flop synchronizer and asserts both outputs three edges after the pin falls. After the pin rises, both outputs stay 1 for DELAY_CYC+1 edges and drop after edge DELAY_CYC+2.
- R5: An active external pin sets flag bit 1, and the flag is visible once both outputs assert.
- R6: A `wdt_req` sampled high in `ST_RUN` asserts `wdt_sys_rst` for exactly DELAY_CYC clock cycles while `sys_rst` stays 0. It also sets flag bit 2.
- R7: Any active source reloads the counter. If `wdt_req` is held for N edges, `wdt_sys_rst` drops after edge N+DELAY_CYC, counting from the first sampling edge as edge 1.
- R8: A write with `flag_we` high clears exactly the flag bits whose `flag_wdata` bit is 1. Flag bits whose data bit is 0 keep their value.
- R9: A write that clears a bit in the same cycle as a new event for that bit leaves the bit set.
- R10: `flag_rdata` always shows the current flag register: bit 0 is power-on, bit 1 is the external pin, bit 2 is the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | 1 when the supply is above threshold; 0 resets the block asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous, active high |
| flag_we | input | 1 | Flag clear write strobe |
| flag_wdata | input | 3 | Write-1-to-clear mask |
| flag_rdata | output | 3 | Flag register contents |
| sys_rst | output | 1 | General system reset, active high |
| wdt_sys_rst | output | 1 | Watchdog-domain system reset, active high |

## Verification
The bench measures each release edge exactly: after a supply rise, after an external pin release, and after a single or a held watchdog request. An off-by-one counter or a missing synchronizer stage therefore shows up as a release one cycle early or late. It drops the supply during the stretch and during run to catch a counter that resumes instead of restarting. It also checks without a clock edge, so an output that asserts synchronously would show a stale 0. A write-to-clear that collides with a new watchdog event would lose the flag if the set had the lower priority. A watchdog request that wrongly drove the general reset would show `sys_rst` high during the random phase.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int FLAG_W  = 3;
    localparam int FLG_POC = 0;
    localparam int FLG_EXT = 1;
    localparam int FLG_WDT = 2;

    typedef enum logic [1:0] {
        ST_STRETCH = 2'd0,
        ST_RUN     = 2'd1,
        ST_WDT     = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_n,
    output logic active
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '1;
        else         chain <= {chain[STAGES-2:0], pin_n};
    end

    assign active = ~chain[STAGES-1];
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
    parameter int DELAY_CYC = 64
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)              cnt <= RELOAD;
        else if (load)            cnt <= RELOAD;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R7
    reload_value_chk: assert property (@(posedge clk) disable iff (!arst_n)
        load |=> cnt == RELOAD);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt <= RELOAD);
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags
    import rsq_pkg::*;
(
    input  logic              clk,
    input  logic              arst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_data,
    output logic [FLAG_W-1:0] flags
);
    localparam logic [FLAG_W-1:0] POC_VAL = FLAG_W'(1) << FLG_POC;

    logic [FLAG_W-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_data : '0;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) flags <= POC_VAL;
        else         flags <= (flags & ~clr_mask) | set_vec;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
        |set_vec |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (clr_we && set_vec == '0) |=> ((flags & $past(clr_data)) == '0));
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic ext_act,
    input  logic wdt_req,
    input  logic cnt_zero,
    output logic cnt_dec,
    output logic sys_rst,
    output logic wdt_sys_rst
);
    rsq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STRETCH: if (!ext_act && !wdt_req && cnt_zero) state_nx = ST_RUN;
            ST_RUN: begin
                if (ext_act)      state_nx = ST_STRETCH;
                else if (wdt_req) state_nx = ST_WDT;
            end
            ST_WDT: begin
                if (ext_act)                   state_nx = ST_STRETCH;
                else if (!wdt_req && cnt_zero) state_nx = ST_RUN;
            end
            default: state_nx = ST_STRETCH;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_STRETCH;
        else         state <= state_nx;
    end

    always_comb begin
        sys_rst     = 1'b1;
        wdt_sys_rst = 1'b1;
        cnt_dec     = 1'b1;
        unique case (state)
            ST_STRETCH: begin sys_rst = 1'b1; wdt_sys_rst = 1'b1; cnt_dec = 1'b1; end
            ST_RUN:     begin sys_rst = 1'b0; wdt_sys_rst = 1'b0; cnt_dec = 1'b0; end
            ST_WDT:     begin sys_rst = 1'b0; wdt_sys_rst = 1'b1; cnt_dec = 1'b1; end
            default:    begin sys_rst = 1'b1; wdt_sys_rst = 1'b1; cnt_dec = 1'b1; end
        endcase
    end

    // R4
    ext_asserts_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ext_act |=> (sys_rst && wdt_sys_rst));

    // R6
    wdt_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!sys_rst && !ext_act && wdt_req) |=> (wdt_sys_rst && !sys_rst));

    // R1
    outputs_nested_chk: assert property (@(posedge clk) disable iff (!arst_n)
        sys_rst |-> wdt_sys_rst);
endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq
    import rsq_pkg::*;
#(
    parameter int DELAY_CYC = 64
) (
    input  logic              clk,
    input  logic              supply_ok,
    input  logic              ext_rst_n,
    input  logic              wdt_req,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [FLAG_W-1:0] flag_rdata,
    output logic              sys_rst,
    output logic              wdt_sys_rst
);
    logic ext_act;
    logic cnt_zero;
    logic cnt_dec;
    logic [FLAG_W-1:0] set_vec;

    rsq_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (supply_ok),
        .pin_n  (ext_rst_n),
        .active (ext_act)
    );

    rsq_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk    (clk),
        .arst_n (supply_ok),
        .load   (ext_act | wdt_req),
        .dec    (cnt_dec),
        .zero   (cnt_zero)
    );

    rsq_fsm u_fsm (
        .clk         (clk),
        .arst_n      (supply_ok),
        .ext_act     (ext_act),
        .wdt_req     (wdt_req),
        .cnt_zero    (cnt_zero),
        .cnt_dec     (cnt_dec),
        .sys_rst     (sys_rst),
        .wdt_sys_rst (wdt_sys_rst)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_EXT] = ext_act;
        set_vec[FLG_WDT] = wdt_req;
    end

    rsq_flags u_flags (
        .clk      (clk),
        .arst_n   (supply_ok),
        .set_vec  (set_vec),
        .clr_we   (flag_we),
        .clr_data (flag_wdata),
        .flags    (flag_rdata)
    );

    // R5
    ext_flag_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        ext_act |=> flag_rdata[FLG_EXT]);
endmodule

// File: tb/rsq_reset_seq_bench.sv
module rsq_reset_seq_bench;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_req = 1'b0;
    logic       flag_we = 1'b0;
    logic [2:0] flag_wdata = '0;
    logic [2:0] flag_rdata;
    logic       sys_rst, wdt_sys_rst;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rsq_reset_seq #(.DELAY_CYC(D)) u_rsq_reset_seq (
        .clk(clk), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n), .wdt_req(wdt_req),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
        .sys_rst(sys_rst), .wdt_sys_rst(wdt_sys_rst)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk_out(string req, logic s, logic w);
        chk(req, {6'd0, sys_rst, wdt_sys_rst}, {6'd0, s, w});
    endtask

    function automatic logic [2:0] flag_next(logic [2:0] f, logic we, logic [2:0] wd, logic [2:0] setv);
        return (f & ~(we ? wd : 3'b000)) | setv;
    endfunction

    initial begin
        int wd_cnt = 0;
        while (!done) begin
            @(posedge clk);
            wd_cnt++;
            if (wd_cnt > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0] mflags;
        logic       mwdt;
        int         mcnt;
        void'($urandom(32'd4711));
        @(negedge clk);
        tick(3);
        // R1 reset state
        chk_out("R1", 1'b1, 1'b1);
        chk("R1 flags", {5'd0, flag_rdata}, 8'h01);

        // R2 release after D edges
        supply_ok = 1'b1;
        for (int k = 1; k <= D; k++) begin
            tick(1);
            if (k < D) chk_out("R2 hold", 1'b1, 1'b1);
            else       chk_out("R2 release", 1'b0, 1'b0);
        end
        chk("R10", {5'd0, flag_rdata}, 8'h01);

        // R8 clear with zero mask, then clear bit 0
        flag_we = 1'b1; flag_wdata = 3'b110; tick(1);
        chk("R8 untouched", {5'd0, flag_rdata}, 8'h01);
        flag_wdata = 3'b001; tick(1);
        flag_we = 1'b0;
        chk("R8 cleared", {5'd0, flag_rdata}, 8'h00);

        // R6 single watchdog request
        wdt_req = 1'b1; tick(1); wdt_req = 1'b0;
        chk("R6 flag", {5'd0, flag_rdata}, 8'h04);
        chk_out("R6 first", 1'b0, 1'b1);
        for (int k = 2; k <= D + 1; k++) begin
            tick(1);
            if (k <= D) chk_out("R6 hold", 1'b0, 1'b1);
            else        chk_out("R6 release", 1'b0, 1'b0);
        end

        // R7 held request of 3 edges
        wdt_req = 1'b1; tick(3); wdt_req = 1'b0;
        tick(D - 1);
        chk_out("R7 hold", 1'b0, 1'b1);
        tick(1);
        chk_out("R7 release", 1'b0, 1'b0);

        // R4 / R5 external pin
        flag_we = 1'b1; flag_wdata = 3'b111; tick(1); flag_we = 1'b0;
        ext_rst_n = 1'b0;
        tick(2);
        chk_out("R4 sync latency", 1'b0, 1'b0);
        tick(1);
        chk_out("R4 assert", 1'b1, 1'b1);
        chk("R5 flag", {5'd0, flag_rdata}, 8'h02);
        tick(4);
        ext_rst_n = 1'b1;
        tick(D + 1);
        chk_out("R4 hold", 1'b1, 1'b1);
        tick(1);
        chk_out("R4 release", 1'b0, 1'b0);

        // R1 asynchronous assertion, R3 restart from run
        supply_ok = 1'b0; #1;
        chk_out("R1 async", 1'b1, 1'b1);
        chk("R1 flags", {5'd0, flag_rdata}, 8'h01);
        @(negedge clk);
        supply_ok = 1'b1;
        tick(D / 2);
        supply_ok = 1'b0; #1;
        chk_out("R3 drop in stretch", 1'b1, 1'b1);
        @(negedge clk);
        supply_ok = 1'b1;
        tick(D - 1);
        chk_out("R3 restart hold", 1'b1, 1'b1);
        tick(1);
        chk_out("R3 restart release", 1'b0, 1'b0);

        // R9 write collides with new event
        flag_we = 1'b1; flag_wdata = 3'b101; wdt_req = 1'b1; tick(1);
        flag_we = 1'b0; wdt_req = 1'b0;
        chk("R9", {5'd0, flag_rdata}, 8'h04);
        tick(D + 1);
        chk_out("R6 settle", 1'b0, 1'b0);

        // Random phase: R6 R7 R8 R9 R10 against bench model
        mflags = flag_rdata;
        mwdt = 1'b0; mcnt = 0;
        for (int i = 0; i < 600; i++) begin
            logic       r_wdt, r_we;
            logic [2:0] r_wd;
            r_wdt = ($urandom % 16) == 0;
            r_we  = ($urandom % 4) == 0;
            r_wd  = 3'($urandom);
            wdt_req = r_wdt; flag_we = r_we; flag_wdata = r_wd;
            tick(1);
            mflags = flag_next(mflags, r_we, r_wd, {r_wdt, 2'b00});
            if (r_wdt) begin mwdt = 1'b1; mcnt = D - 1; end
            else if (mwdt) begin
                if (mcnt == 0) mwdt = 1'b0; else mcnt--;
            end
            chk("R10 random flags", {5'd0, flag_rdata}, {5'd0, mflags});
            chk_out("R6 random outputs", 1'b0, mwdt);
        end
        wdt_req = 1'b0; flag_we = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule